// File: doc/BRIEF.md
# Addressed Serial Receiver with Receive Queue

This block receives asynchronous serial frames on one line, samples each bit at the middle of its cell using a 16x oversampling tick, and stores received bytes in a 16-entry queue that a host pops one entry at a time. Every frame carries a start bit, eight data bits (least significant first), one address-marker bit and a stop bit. A marker value of 1 flags the byte as a station address; 0 flags it as ordinary data.

In address-filter mode, armed by a one-cycle `wake_set` pulse, the receiver silently skips data frames until an address frame arrives. That address is queued, the ready flag is raised, and the filter disarms itself in hardware. The host then compares the queued byte with its own station number. On a mismatch it re-arms the filter. On a match it simply reads the data frames that follow.

Six sticky status bits report ready data, idle timeout with a partly filled queue, overrun, stop-bit error, line break and a summary error. The host clears a bit by reading the status and then writing 0 to that bit. A set error, idle timeout or overrun stops the receiver from accepting new frames until the host clears it. For overrun, the `ovr_cont` input can instead let reception carry on.

Top module: `mp_uart_rx`

## Requirements
- R1: With `rx_en`=1, a frame (low start bit, 8 data bits LSB first, marker bit, high stop bit; each bit 16 `os_tick` periods) whose start bit is still low at its midpoint is queued with its 8 data bits as received.
- R2: The queue holds up to 16 bytes in arrival order. `rd_data` shows the oldest byte, `rd_en` removes it, and `rx_level` gives the entry count, never above 16.
- R3: While `mpie`=1, a frame with marker bit 0 is neither queued nor reflected in any status bit, even if its stop bit is low.
- R4: While `mpie`=1, an address frame (marker 1) with a good stop bit is queued, sets status bit 0 (ready) and drops `mpie` to 0. A `wake_set` pulse sets `mpie` to 1 again.
- R5: A low stop bit sets status bit 3 (stop error) and bit 5 (summary error), and the frame is not queued.
- R6: If the line stays low for 176 further ticks after a low stop bit, status bit 4 (break) is set. If the line returns high first, bit 4 stays 0.
- R7: Status bit 1 (idle timeout) sets when the queue holds 1 to 7 entries and 240 ticks have passed since the last stop bit with no new start bit. It stays 0 when 8 or more entries are held.
- R8: A good frame that completes while 16 entries are held sets status bit 2 (overrun) and is dropped. Status bit 0 also sets when a push brings the count to 8.
- R9: While status bit 2 is 1, `ovr_cont`=1 lets new frames be queued and `ovr_cont`=0 blocks them. Status bits 1, 4 and 5 block new frames regardless of `ovr_cont`.
- R10: A status bit clears only when a `stat_wr` write with 0 in that bit follows a `stat_rd` read that saw it as 1. Bit 3 clears together with bit 5.
- R11: With `rx_en`=0, line activity changes neither the queue nor the status.
- R12: After reset, `status`=0, `rx_level`=0 and `mpie`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit |
| rxd | input | 1 | Serial receive line |
| rx_en | input | 1 | Receiver enable |
| ovr_cont | input | 1 | Keep receiving while overrun is flagged |
| wake_set | input | 1 | Pulse: arm the address filter |
| rd_en | input | 1 | Pop the oldest queued byte |
| rd_data | output | 8 | Oldest queued byte |
| rx_level | output | 5 | Number of queued bytes |
| stat_rd | input | 1 | Status read strobe |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 6 | Status write data |
| status | output | 6 | Status flags |
| mpie | output | 1 | Address filter armed |

## Verification
Most internal faults reach the ports within one frame. A mis-sampled bit position or a wrong shift direction corrupts `rd_data` on the first non-symmetric byte. A filter-state error shows up as an extra or missing `rx_level` step within one frame time. A bad counter limit moves the break or idle-timeout flag outside its 176- or 240-tick window, and the directed checks placed on both sides of each window catch that shift. Flag-clear and halt faults show as a status bit that survives a read-then-write-zero sequence, or as a queue count that moves while reception should be blocked.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int NFLAG  = 6;
  localparam int FL_RDY = 0;
  localparam int FL_IDL = 1;
  localparam int FL_OVR = 2;
  localparam int FL_FER = 3;
  localparam int FL_BRK = 4;
  localparam int FL_ERR = 5;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_WAITHI
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       mpb;
    logic       stop_ok;
  } rx_frame_t;
endpackage

// File: rtl/mpu_rx_frame.sv
module mpu_rx_frame
  import mpu_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int NBITS    = 10,
  parameter int BRK_BITS = 11
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  input  logic      run_en,
  input  logic      hunt_en,
  output logic      done,
  output rx_frame_t frame,
  output logic      busy,
  output logic      brk_hit
);
  localparam int BRK_LIM = OSR * BRK_BITS;
  localparam int CW      = $clog2(BRK_LIM + 1);
  localparam int BW      = $clog2(NBITS);
  localparam int HALF    = OSR / 2;

  logic            rx_q1, rx_s;
  rx_state_e       state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [BW-1:0]   bit_q, bit_d;
  logic [8:0]      sh_q, sh_d;
  logic            done_d, brk_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    done_d  = 1'b0;
    brk_d   = 1'b0;
    if (!run_en) begin
      state_d = RX_IDLE;
      cnt_d   = '0;
    end else if (tick) begin
      unique case (state_q)
        RX_IDLE: begin
          if (hunt_en && !rx_s) begin
            state_d = RX_START;
            cnt_d   = '0;
          end
        end
        RX_START: begin
          if (cnt_q == CW'(HALF - 1)) begin
            cnt_d   = '0;
            bit_d   = '0;
            state_d = rx_s ? RX_IDLE : RX_BITS;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_BITS: begin
          if (cnt_q == CW'(OSR - 1)) begin
            cnt_d = '0;
            if (bit_q == BW'(NBITS - 1)) begin
              done_d  = 1'b1;
              state_d = rx_s ? RX_IDLE : RX_WAITHI;
            end else begin
              sh_d  = {rx_s, sh_q[8:1]};
              bit_d = bit_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_WAITHI: begin
          if (rx_s) begin
            state_d = RX_IDLE;
            cnt_d   = '0;
          end else if (cnt_q != CW'(BRK_LIM)) begin
            cnt_d = cnt_q + 1'b1;
            brk_d = (cnt_q == CW'(BRK_LIM - 1));
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q1   <= 1'b1;
      rx_s    <= 1'b1;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      done    <= 1'b0;
      brk_hit <= 1'b0;
      frame   <= '0;
    end else begin
      rx_q1   <= rxd;
      rx_s    <= rx_q1;
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      done    <= done_d;
      brk_hit <= brk_d;
      if (done_d) begin
        frame <= '{data: sh_q[7:0], mpb: sh_q[8], stop_ok: rx_s};
      end
    end
  end

  assign busy = (state_q != RX_IDLE);
endmodule

// File: rtl/mpu_rx_fifo.sv
module mpu_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] lvl_d;
  logic          do_push, do_pop, empty;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    lvl_d = level;
    if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      lvl_d = level + 1'b1;
    else if (do_pop && !do_push) lvl_d = level - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      level <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      level <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end
endmodule

// File: rtl/mpu_rx_flags.sv
module mpu_rx_flags
  import mpu_pkg::*;
#(
  parameter int TRIG     = 8,
  parameter int IDLE_LIM = 240,
  parameter int LW       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             busy,
  input  logic [LW-1:0]    level,
  input  logic             ev_rdy,
  input  logic             ev_fer,
  input  logic             ev_brk,
  input  logic             ev_ovr,
  input  logic             stat_rd,
  input  logic             stat_wr,
  input  logic [NFLAG-1:0] wdata,
  output logic [NFLAG-1:0] flags
);
  localparam int TW = $clog2(IDLE_LIM + 1);

  logic [TW-1:0]    tmr_q, tmr_d;
  logic [NFLAG-1:0] fl_d, seen_q, seen_d, set_v, clr_v;
  logic             ev_idl;

  always_comb begin
    tmr_d = tmr_q;
    if (busy) tmr_d = '0;
    else if (tick && tmr_q != TW'(IDLE_LIM)) tmr_d = tmr_q + 1'b1;
  end

  assign ev_idl = (tmr_q == TW'(IDLE_LIM)) && (level != '0) && (level < LW'(TRIG));

  always_comb begin
    set_v         = '0;
    set_v[FL_RDY] = ev_rdy;
    set_v[FL_IDL] = ev_idl;
    set_v[FL_OVR] = ev_ovr;
    set_v[FL_FER] = ev_fer;
    set_v[FL_BRK] = ev_brk;
    set_v[FL_ERR] = ev_fer;
    clr_v = '0;
    if (stat_wr) begin
      clr_v         = seen_q & ~wdata;
      clr_v[FL_FER] = clr_v[FL_ERR];
    end
    fl_d = (flags & ~clr_v) | set_v;
    if (stat_rd)      seen_d = flags;
    else if (stat_wr) seen_d = '0;
    else              seen_d = seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      flags  <= '0;
      seen_q <= '0;
    end else begin
      tmr_q  <= tmr_d;
      flags  <= fl_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mpu_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TRIG     = 8,
  parameter int OSR      = 16,
  parameter int IDLE_ETU = 15,
  parameter int LW       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_tick,
  input  logic             rxd,
  input  logic             rx_en,
  input  logic             ovr_cont,
  input  logic             wake_set,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic [LW-1:0]    rx_level,
  input  logic             stat_rd,
  input  logic             stat_wr,
  input  logic [NFLAG-1:0] stat_wdata,
  output logic [NFLAG-1:0] status,
  output logic             mpie
);
  logic      rst_q1, rst_i;
  logic      fr_done, fr_busy, fr_brk, fr_mpb, fr_stop;
  rx_frame_t fr;
  logic      halt, accept, good, full, push, push_id, ev_rdy, ev_fer, ev_ovr;
  logic      mpie_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_i  <= rst_q1;
    end
  end

  assign halt = status[FL_ERR] | status[FL_BRK] | status[FL_IDL] |
                (status[FL_OVR] & ~ovr_cont);

  mpu_rx_frame #(.OSR(OSR)) u_frame (
    .clk     (clk),
    .rst_n   (rst_i),
    .tick    (os_tick),
    .rxd     (rxd),
    .run_en  (rx_en),
    .hunt_en (!halt),
    .done    (fr_done),
    .frame   (fr),
    .busy    (fr_busy),
    .brk_hit (fr_brk)
  );

  assign fr_mpb  = fr.mpb;
  assign fr_stop = fr.stop_ok;

  always_comb begin
    accept  = fr_done && !(mpie && !fr_mpb);
    ev_fer  = accept && !fr_stop;
    good    = accept && fr_stop;
    ev_ovr  = good && full;
    push    = good && !full;
    push_id = push && mpie;
    ev_rdy  = push_id || (push && rx_level == LW'(TRIG - 1));
    mpie_d  = mpie;
    if (wake_set)     mpie_d = 1'b1;
    else if (push_id) mpie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) mpie <= 1'b0;
    else        mpie <= mpie_d;
  end

  mpu_rx_fifo #(.W(8), .DEPTH(DEPTH), .LW(LW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_i),
    .push  (push),
    .din   (fr.data),
    .pop   (rd_en),
    .dout  (rd_data),
    .level (rx_level),
    .full  (full)
  );

  mpu_rx_flags #(.TRIG(TRIG), .IDLE_LIM(OSR * IDLE_ETU), .LW(LW)) u_flags (
    .clk     (clk),
    .rst_n   (rst_i),
    .tick    (os_tick),
    .busy    (fr_busy),
    .level   (rx_level),
    .ev_rdy  (ev_rdy),
    .ev_fer  (ev_fer),
    .ev_brk  (fr_brk),
    .ev_ovr  (ev_ovr),
    .stat_rd (stat_rd),
    .stat_wr (stat_wr),
    .wdata   (stat_wdata),
    .flags   (status)
  );
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          mpb,
  input logic          stop_ok,
  input logic          mpie,
  input logic          wake_set,
  input logic          push,
  input logic          rd_en,
  input logic          stat_wr,
  input logic [LW-1:0] rx_level,
  input logic [5:0]    status
);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LW'(DEPTH));

  p_skip_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mpie && done && !mpb) |-> !push);

  p_id_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mpie && done && mpb && stop_ok && rx_level != LW'(DEPTH) && !wake_set)
      |=> (!mpie && status[0]));

  p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == LW'(DEPTH) && !rd_en && done && stop_ok && !(mpie && !mpb))
      |=> (rx_level == LW'(DEPTH) && status[2]));

  p_sticky_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && !stat_wr) |=> status[2]);

  p_sticky_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !stat_wr) |=> status[5]);
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .done     (fr_done),
  .mpb      (fr_mpb),
  .stop_ok  (fr_stop),
  .mpie     (mpie),
  .wake_set (wake_set),
  .push     (push),
  .rd_en    (rd_en),
  .stat_wr  (stat_wr),
  .rx_level (rx_level),
  .status   (status)
);

// File: tb/mp_uart_rx_tb.sv
module mp_uart_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n, os_tick, rxd, rx_en, ovr_cont, wake_set, rd_en;
  logic       stat_rd, stat_wr;
  logic [5:0] stat_wdata, status;
  logic [7:0] rd_data;
  logic [4:0] rx_level;
  logic       mpie;
  int         n_chk = 0;
  int         n_err = 0;
  bit         finished = 0;

  always #5 clk = ~clk;

  mp_uart_rx u_dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .rx_en(rx_en),
    .ovr_cont(ovr_cont), .wake_set(wake_set), .rd_en(rd_en), .rd_data(rd_data),
    .rx_level(rx_level), .stat_rd(stat_rd), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .status(status), .mpie(mpie)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic v);
    @(negedge clk) rxd = v;
    repeat (15) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic mpb, input logic stop, input bit hold);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(d[i]);
    bit_out(mpb);
    bit_out(stop);
    if (!hold) rxd = 1'b1;
    wait_cyc(3);
  endtask

  task automatic pop();
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
  endtask

  task automatic st_read();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
  endtask

  task automatic st_write(input logic [5:0] v);
    @(negedge clk) begin stat_wr = 1'b1; stat_wdata = v; end
    @(negedge clk) stat_wr = 1'b0;
  endtask

  task automatic clean();
    while (rx_level != 0) pop();
    st_read();
    st_write(6'b0);
    wait_cyc(2);
  endtask

  task automatic t_reset();
    chk("R12 status", status, 0);
    chk("R12 level", rx_level, 0);
    chk("R12 mpie", mpie, 0);
  endtask

  task automatic t_basic();
    send(8'hA5, 1'b0, 1'b1, 0);
    send(8'h3C, 1'b1, 1'b1, 0);
    send(8'h01, 1'b0, 1'b1, 0);
    chk("R2 level after 3", rx_level, 3);
    chk("R1 byte0", rd_data, 8'hA5); pop();
    chk("R1 byte1", rd_data, 8'h3C); pop();
    chk("R2 order byte2", rd_data, 8'h01); pop();
    chk("R2 level drained", rx_level, 0);
    clean();
  endtask

  task automatic t_wake();
    @(negedge clk) wake_set = 1'b1;
    @(negedge clk) wake_set = 1'b0;
    chk("R4 armed", mpie, 1);
    send(8'h11, 1'b0, 1'b1, 0);
    chk("R3 data skipped level", rx_level, 0);
    send(8'h55, 1'b0, 1'b0, 0);
    wait_cyc(4);
    chk("R3 bad stop no flags", status, 0);
    send(8'h5A, 1'b1, 1'b1, 0);
    chk("R4 id queued", rx_level, 1);
    chk("R4 id data", rd_data, 8'h5A);
    chk("R4 ready set", status[0], 1);
    chk("R4 disarmed", mpie, 0);
    clean();
    @(negedge clk) wake_set = 1'b1;
    @(negedge clk) wake_set = 1'b0;
    chk("R4 rearmed", mpie, 1);
    send(8'h22, 1'b0, 1'b1, 0);
    chk("R3 second skip", rx_level, 0);
    send(8'h33, 1'b1, 1'b1, 0);
    chk("R4 second id", rd_data, 8'h33);
    send(8'h44, 1'b0, 1'b1, 0);
    chk("R4 data after id", rx_level, 2);
    clean();
  endtask

  task automatic t_fer();
    send(8'h77, 1'b0, 1'b0, 0);
    chk("R5 fer", status[3], 1);
    chk("R5 err", status[5], 1);
    chk("R5 not queued", rx_level, 0);
    wait_cyc(300);
    chk("R6 no brk when line high", status[4], 0);
    clean();
  endtask

  task automatic t_brk();
    send(8'h00, 1'b0, 1'b0, 1);
    wait_cyc(100);
    chk("R6 brk not yet", status[4], 0);
    wait_cyc(200);
    chk("R6 brk set", status[4], 1);
    @(negedge clk) rxd = 1'b1;
    wait_cyc(4);
    clean();
    chk("R10 brk cleared", status, 0);
  endtask

  task automatic t_idle();
    send(8'h12, 1'b0, 1'b1, 0);
    wait_cyc(200);
    chk("R7 idle not yet", status[1], 0);
    wait_cyc(60);
    chk("R7 idle set", status[1], 1);
    chk("R7 ready not set below trig", status[0], 0);
    clean();
    for (int i = 0; i < 8; i++) send(8'(i), 1'b0, 1'b1, 0);
    wait_cyc(300);
    chk("R7 no idle at trig", status[1], 0);
    chk("R8 ready at eight", status[0], 1);
    clean();
  endtask

  task automatic t_ovr();
    ovr_cont = 1'b1;
    for (int i = 0; i < 16; i++) send(8'(i + 16), 1'b0, 1'b1, 0);
    chk("R2 full", rx_level, 16);
    send(8'hEE, 1'b0, 1'b1, 0);
    chk("R8 overrun", status[2], 1);
    chk("R8 dropped", rx_level, 16);
    chk("R2 head kept", rd_data, 16);
    pop();
    send(8'h99, 1'b0, 1'b1, 0);
    chk("R9 continue", rx_level, 16);
    clean();
    ovr_cont = 1'b0;
    for (int i = 0; i < 17; i++) send(8'(i), 1'b0, 1'b1, 0);
    chk("R8 overrun again", status[2], 1);
    pop();
    send(8'h98, 1'b0, 1'b1, 0);
    chk("R9 halted", rx_level, 15);
    clean();
    ovr_cont = 1'b1;
  endtask

  task automatic t_clear();
    send(8'h66, 1'b0, 1'b0, 0);
    st_write(6'b0);
    chk("R10 no clear without read", status[5], 1);
    st_read();
    st_write(6'b100000);
    chk("R10 write one keeps", status[5], 1);
    st_read();
    st_write(6'b0);
    chk("R10 err cleared", status[5], 0);
    chk("R10 fer cleared", status[3], 0);
  endtask

  task automatic t_ren();
    rx_en = 1'b0;
    send(8'h0F, 1'b0, 1'b1, 0);
    chk("R11 no queue", rx_level, 0);
    chk("R11 no status", status, 0);
    rx_en = 1'b1;
    send(8'hF0, 1'b0, 1'b1, 0);
    chk("R11 resumes", rd_data, 8'hF0);
    clean();
  endtask

  initial begin
    rst_n = 1'b0; os_tick = 1'b1; rxd = 1'b1; rx_en = 1'b1; ovr_cont = 1'b1;
    wake_set = 1'b0; rd_en = 1'b0; stat_rd = 1'b0; stat_wr = 1'b0; stat_wdata = '0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_basic();
    t_wake();
    t_fer();
    t_brk();
    t_idle();
    t_ovr();
    t_clear();
    t_ren();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule